// File: doc/BRIEF.md
# Serial ADC Conversion Readout Controller

This block runs a 16-bit converter that reports its result over a serial line. After system reset it holds the converter's reset line low for a fixed number of cycles. It then polls the end-of-conversion flag until calibration has finished. From then on it accepts conversion requests from a host. For each request it issues a start pulse that is gated by the converter clock. It waits for the end-of-conversion flag to rise and then fall. It then lowers chip select and runs a serial clock that idles low, collecting 16 bits with the most significant bit first.

The capture edge is set by a mode input. In slow mode each bit is sampled on the rising serial-clock edge that follows the falling edge that launched it. In fast mode the bit is sampled on the next falling edge instead, which allows short clock periods when the output settles late after a falling edge. The serial-clock half period is a run-time input in system clock cycles. The end-of-conversion flag passes through a synchronizer before use.

The host sees a busy flag, a one-cycle valid strobe and the captured word.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset is released, `adc_rst_n` stays low for exactly RST_CYC system cycles (default 4) and then goes high. `host_busy` stays high until the synchronized EOC has been seen low after that.
- R2: A `host_start` that arrives before calibration completes produces no start pulse at `adc_start_n`, either at that time or afterwards.
- R3: A start accepted in idle drives `adc_start_n` low for START_CYC cycles. During that time `adc_start_n` is low only while `adc_clk` is low.
- R4: Chip select `adc_cs_n` falls only after `adc_eoc` has risen and then fallen following the start pulse.
- R5: `adc_sclk` is low whenever `adc_cs_n` is high. During a frame it runs 17 periods, each of 2*`sclk_half` system cycles (a `sclk_half` of 0 acts as 1).
- R6: With `fast_mode`=0, bits are sampled on rising `adc_sclk` edges 2 to 17. The first sampled bit lands in bit 15 of `host_data`.
- R7: With `fast_mode`=1, bits are sampled on falling `adc_sclk` edges 2 to 17. This gives the correct word even when DOUT changes after the following rising edge.
- R8: `host_busy` is high from the cycle after a start is accepted until `host_valid` pulses. `host_valid` lasts one cycle with `host_busy` low, and `host_data` holds the word from then on.
- R9: A `host_start` while busy is ignored. The frame in progress completes with correct data, and no second conversion follows.
- R10: A start asserted in the same cycle as `host_valid` is accepted and runs a complete second conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_start | input | 1 | Conversion request, sampled when idle |
| fast_mode | input | 1 | 0: capture on rising SCLK, 1: capture on falling SCLK |
| sclk_half | input | HALF_W | SCLK half period in system cycles |
| adc_clk | input | 1 | Converter clock, used to gate the start pulse |
| adc_eoc | input | 1 | End-of-conversion flag, asynchronous, low = done |
| adc_dout | input | 1 | Serial data from the converter |
| host_busy | output | 1 | Calibration or conversion in progress |
| host_valid | output | 1 | One-cycle strobe for a new result |
| host_data | output | WORD_W | Last captured word |
| adc_rst_n | output | 1 | Converter reset, active low |
| adc_start_n | output | 1 | Converter start request, active low |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_sclk | output | 1 | Serial clock, idles low |

## Verification
A wrong sequencer state shows up as chip select falling while EOC is still high, or as a start pulse during calibration. Either is visible within one system cycle of the faulty edge. A miscounted capture or a wrong edge choice corrupts `host_data`, and the error becomes visible at the `host_valid` strobe that ends the frame. The bench models the converter with a DOUT delay longer than half of the fastest SCLK period, so a wrong edge choice in fast mode corrupts the word instead of passing unnoticed. A serial-clock divider fault changes the rising-edge spacing, and the bench flags it from the next edge inside the frame.

// File: rtl/adc_rd_pkg.sv
// Shared types for the serial ADC readout controller.
// Assumes: a single clock domain for the sequencer; converter signals are external.
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_RST   = 3'd0,   // converter reset pulse
        ST_CAL   = 3'd1,   // polling EOC for calibration end
        ST_IDLE  = 3'd2,   // ready for a host request
        ST_START = 3'd3,   // start pulse to converter
        ST_WHI   = 3'd4,   // wait for EOC to rise
        ST_WLO   = 3'd5,   // wait for EOC to fall (result ready)
        ST_XFER  = 3'd6,   // serial frame running
        ST_DONE  = 3'd7    // latch result
    } rd_state_e;

endpackage

// File: rtl/rd_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes: STAGES >= 2; INIT is the reset value held in every stage.
module rd_sync #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] ff;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) ff <= {STAGES{INIT}};
        else        ff <= {ff[STAGES-2:0], d};
    end

    assign q = ff[STAGES-1];

endmodule

// File: rtl/rd_sclk_gen.sv
// Serial clock divider. While run is high, SCLK toggles every eff_half cycles,
// starting low. rise_t and fall_t are high in the cycle whose edge moves SCLK.
// Assumes: half of zero is treated as one (divide by two).
module rd_sclk_gen #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              sclk,
    output logic              rise_t,
    output logic              fall_t
);

    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] eff_half;
    logic              tick;

    // Clamp the half period to at least one cycle.
    always_comb eff_half = (half == '0) ? HALF_W'(1) : half;

    // Terminal count of the half-period counter.
    always_comb tick = run && (cnt == (eff_half - HALF_W'(1)));

    assign rise_t = tick && !sclk;
    assign fall_t = tick &&  sclk;

    // Half-period counter and SCLK register; both park at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (tick) begin
            cnt  <= '0;
            sclk <= !sclk;
        end else begin
            cnt  <= cnt + HALF_W'(1);
        end
    end

    // SCLK must sit low the cycle after the divider is stopped.
    p_sclk_parks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk);

endmodule

// File: rtl/rd_shift_in.sv
// Serial capture of one frame. Counts falling SCLK edges; from the second
// SCLK period on, samples din on the rising edge (slow) or the falling edge
// (fast). frame_end flags the falling edge that completes WORD_W+1 periods.
// Assumes: active is held high for the whole frame and low between frames.
module rd_shift_in #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              fast,
    input  logic              rise_t,
    input  logic              fall_t,
    input  logic              din,
    output logic [WORD_W-1:0] word,
    output logic              frame_end
);

    localparam int CNT_W = $clog2(WORD_W + 2);

    logic [CNT_W-1:0] fall_cnt;
    logic [CNT_W-1:0] cap_cnt;
    logic             cap;

    // Select the capture edge; the first period only launches the MSB.
    always_comb cap = active && (fall_cnt != '0) && (fast ? fall_t : rise_t);

    assign frame_end = active && fall_t && (fall_cnt == CNT_W'(WORD_W));

    // Falling-edge and capture counters for the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            fall_cnt <= '0;
            cap_cnt  <= '0;
        end else begin
            if (fall_t) fall_cnt <= fall_cnt + CNT_W'(1);
            if (cap)    cap_cnt  <= cap_cnt + CNT_W'(1);
        end
    end

    // Shift register, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)   word <= '0;
        else if (cap) word <= {word[WORD_W-2:0], din};
    end

    // Never more captures than bits in the word.
    p_cap_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_cnt <= CNT_W'(WORD_W));

    // By frame end, all but possibly the last capture are done.
    p_cap_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> (cap_cnt >= CNT_W'(WORD_W - 1)));

endmodule

// File: rtl/adc_rd_ctrl.sv
// Serial ADC readout controller (top). Sequences converter reset and
// calibration, issues start pulses gated by the converter clock, polls the
// synchronized EOC, and runs one serial frame per conversion.
// Assumes: RST_CYC > SYNC_STAGES so the raised EOC is seen before polling,
// START_CYC system cycles cover at least one low phase of adc_clk.
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int HALF_W      = 8,
    parameter int RST_CYC     = 4,
    parameter int START_CYC   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_start,
    input  logic              fast_mode,
    input  logic [HALF_W-1:0] sclk_half,
    input  logic              adc_clk,
    input  logic              adc_eoc,
    input  logic              adc_dout,
    output logic              host_busy,
    output logic              host_valid,
    output logic [WORD_W-1:0] host_data,
    output logic              adc_rst_n,
    output logic              adc_start_n,
    output logic              adc_cs_n,
    output logic              adc_sclk
);

    localparam int TMR_MAX = (RST_CYC > START_CYC) ? RST_CYC : START_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    rd_state_e         state;
    logic [TMR_W-1:0]  tmr;
    logic              cal_done;
    logic              valid_q;
    logic [WORD_W-1:0] result_q;
    logic              eoc_s;
    logic              sclk_run;
    logic              rise_t;
    logic              fall_t;
    logic              frame_end;
    logic [WORD_W-1:0] shift_word;

    rd_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_eoc_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (adc_eoc),
        .q     (eoc_s)
    );

    rd_sclk_gen #(.HALF_W(HALF_W)) u_sclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (sclk_run),
        .half   (sclk_half),
        .sclk   (adc_sclk),
        .rise_t (rise_t),
        .fall_t (fall_t)
    );

    rd_shift_in #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (sclk_run),
        .fast      (fast_mode),
        .rise_t    (rise_t),
        .fall_t    (fall_t),
        .din       (adc_dout),
        .word      (shift_word),
        .frame_end (frame_end)
    );

    // Output decode from the state register.
    always_comb begin
        sclk_run    = (state == ST_XFER);
        adc_cs_n    = !sclk_run;
        adc_rst_n   = (state != ST_RST);
        host_busy   = (state != ST_IDLE);
        adc_start_n = (state != ST_START) || adc_clk;
    end

    assign host_valid = valid_q;
    assign host_data  = result_q;

    // Main sequencer: reset pulse, calibration poll, start, EOC poll, frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_RST;
            tmr      <= '0;
            cal_done <= 1'b0;
            valid_q  <= 1'b0;
            result_q <= '0;
        end else begin
            valid_q <= 1'b0;
            case (state)
                ST_RST: begin
                    if (tmr == TMR_W'(RST_CYC - 1)) begin
                        tmr   <= '0;
                        state <= ST_CAL;
                    end else begin
                        tmr <= tmr + TMR_W'(1);
                    end
                end
                ST_CAL: begin
                    if (!eoc_s) begin
                        cal_done <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
                ST_IDLE: begin
                    if (host_start) begin
                        tmr   <= '0;
                        state <= ST_START;
                    end
                end
                ST_START: begin
                    if (tmr == TMR_W'(START_CYC - 1)) begin
                        tmr   <= '0;
                        state <= ST_WHI;
                    end else begin
                        tmr <= tmr + TMR_W'(1);
                    end
                end
                ST_WHI:  if (eoc_s)     state <= ST_WLO;
                ST_WLO:  if (!eoc_s)    state <= ST_XFER;
                ST_XFER: if (frame_end) state <= ST_DONE;
                ST_DONE: begin
                    result_q <= shift_word;
                    valid_q  <= 1'b1;
                    state    <= ST_IDLE;
                end
                default: state <= ST_RST;
            endcase
        end
    end

    // SCLK from the divider stays low outside frames.
    p_cs_sclk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> !adc_sclk);

    // Strobe is a single cycle.
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // No start pulse before calibration has completed.
    p_start_after_cal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START) |-> cal_done);

    // Chip select falls only when synchronized EOC reports done.
    p_cs_waits_eoc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> !eoc_s);

    // A request during a frame does not disturb it.
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && host_start && !frame_end) |=> (state == ST_XFER));

    // Start low level never coincides with a high converter clock.
    p_start_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_clk |-> adc_start_n);

endmodule

// File: tb/sim_adc_rd_ctrl.sv
module sim_adc_rd_ctrl;

    localparam int WORD_W = 16;
    localparam int HALF_W = 8;
    localparam int RST_CYC = 4;
    localparam int CLK_NS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_start = 1'b0;
    logic fast_mode = 1'b0;
    logic [HALF_W-1:0] sclk_half = HALF_W'(4);
    logic adc_clk = 1'b0;
    logic adc_eoc = 1'b1;
    logic adc_dout = 1'b0;
    logic host_busy, host_valid, adc_rst_n, adc_start_n, adc_cs_n, adc_sclk;
    logic [WORD_W-1:0] host_data;

    int n_chk = 0;
    int n_fail = 0;
    int conv_cnt = 0;
    int start_edges = 0;
    int rises = 0;
    int period_bad = 0;
    int cs_early = 0;
    int gate_bad = 0;
    bit finished = 1'b0;
    logic [WORD_W-1:0] stub_word = '0;
    logic [WORD_W-1:0] sr;
    logic prev_cs = 1'b1;
    logic prev_sclk = 1'b0;
    realtime last_rise = 0;
    realtime want_period = 0;

    always #(CLK_NS/2) clk = ~clk;
    always #6 adc_clk = ~adc_clk;

    adc_rd_ctrl #(.WORD_W(WORD_W), .HALF_W(HALF_W), .RST_CYC(RST_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .host_start(host_start), .fast_mode(fast_mode),
        .sclk_half(sclk_half), .adc_clk(adc_clk), .adc_eoc(adc_eoc),
        .adc_dout(adc_dout), .host_busy(host_busy), .host_valid(host_valid),
        .host_data(host_data), .adc_rst_n(adc_rst_n), .adc_start_n(adc_start_n),
        .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk)
    );

    // Converter stub: calibration, then one conversion per start pulse.
    initial begin
        adc_eoc = 1'b1;
        @(posedge adc_rst_n);
        #400 adc_eoc = 1'b0;
        forever begin
            @(negedge adc_start_n);
            conv_cnt++;
            adc_eoc = 1'b1;
            #300 adc_eoc = 1'b0;
        end
    end

    always @(negedge adc_start_n) start_edges++;

    // Serial stub and frame monitor: DOUT settles 6 ns after a falling SCLK.
    always @(adc_cs_n or adc_sclk) begin
        if (prev_cs && !adc_cs_n) begin
            sr = stub_word;
            rises = 0;
            if (adc_eoc) cs_early++;
        end else if (!adc_cs_n && adc_sclk && !prev_sclk) begin
            if (rises > 0 && ($realtime - last_rise) != want_period) period_bad++;
            last_rise = $realtime;
            rises++;
        end else if (!adc_cs_n && !adc_sclk && prev_sclk) begin
            adc_dout <= #6 sr[WORD_W-1];
            sr = {sr[WORD_W-2:0], 1'b0};
        end
        prev_cs = adc_cs_n;
        prev_sclk = adc_sclk;
    end

    // Start must never be low while the converter clock is high.
    always @(negedge clk) if (!adc_start_n && adc_clk) gate_bad++;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        host_start = 1'b1;
        @(negedge clk);
        host_start = 1'b0;
    endtask

    task automatic wait_valid(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (host_valid) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    // R1, R2: reset pulse length, busy through calibration, early start ignored.
    task automatic t_reset_cal();
        int lo = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(adc_cs_n && !adc_sclk && host_busy && !host_valid, "R1 reset state",
            {adc_cs_n, adc_sclk, host_busy, host_valid}, 4'b1010);
        rst_n = 1'b1;
        while (!adc_rst_n && lo < 100) begin
            lo++;
            @(negedge clk);
        end
        chk(lo == RST_CYC, "R1 reset pulse cycles", lo, RST_CYC);
        repeat (10) @(negedge clk);
        chk(host_busy == 1'b1, "R1 busy during calibration", host_busy, 1);
        pulse_start();
        for (int i = 0; i < 1000 && host_busy; i++) @(negedge clk);
        chk(!host_busy, "R1 busy released after calibration", host_busy, 0);
        repeat (50) @(negedge clk);
        chk(start_edges == 0, "R2 early start ignored", start_edges, 0);
    endtask

    // R3-R8: one conversion with given word, mode and divider.
    task automatic t_convert(input logic [WORD_W-1:0] w, input bit fast,
                             input int half, input string req);
        bit seen;
        int c0 = conv_cnt;
        int eff = (half == 0) ? 1 : half;
        stub_word = w;
        fast_mode = fast;
        sclk_half = HALF_W'(half);
        want_period = 2 * eff * CLK_NS;
        period_bad = 0;
        @(negedge clk);
        pulse_start();
        chk(host_busy, "R8 busy after start", host_busy, 1);
        wait_valid(seen);
        chk(seen, {req, " valid seen"}, seen, 1);
        chk(host_data == w, {req, " data"}, host_data, w);
        chk(!host_busy, "R8 busy low at valid", host_busy, 0);
        chk(conv_cnt == c0 + 1, "R3 one start pulse", conv_cnt - c0, 1);
        chk(rises == 17, "R5 sclk periods", rises, 17);
        chk(period_bad == 0, "R5 sclk period", period_bad, 0);
        chk(cs_early == 0, "R4 cs after eoc", cs_early, 0);
        chk(gate_bad == 0, "R3 start gated", gate_bad, 0);
        @(negedge clk);
        chk(!host_valid, "R8 valid one cycle", host_valid, 0);
        chk(host_data == w, "R8 data held", host_data, w);
        chk(adc_cs_n && !adc_sclk, "R5 idle lines", {adc_cs_n, adc_sclk}, 2'b10);
    endtask

    // R9: request during a frame is dropped.
    task automatic t_busy_ignore();
        bit seen;
        int c0 = conv_cnt;
        stub_word = 16'h5AC3;
        fast_mode = 1'b1;
        sclk_half = HALF_W'(3);
        want_period = 24;
        period_bad = 0;
        pulse_start();
        for (int i = 0; i < 2000 && adc_cs_n; i++) @(negedge clk);
        repeat (20) @(negedge clk);
        pulse_start();
        wait_valid(seen);
        chk(seen && host_data == 16'h5AC3, "R9 frame intact", host_data, 16'h5AC3);
        repeat (200) @(negedge clk);
        chk(conv_cnt == c0 + 1, "R9 no extra conversion", conv_cnt - c0, 1);
        chk(!host_busy && adc_cs_n, "R9 idle after", host_busy, 0);
    endtask

    // R10: start in the same cycle as the valid strobe.
    task automatic t_back_to_back();
        bit seen;
        stub_word = 16'h0F1E;
        fast_mode = 1'b0;
        sclk_half = HALF_W'(6);
        want_period = 48;
        pulse_start();
        wait_valid(seen);
        chk(host_data == 16'h0F1E, "R10 first word", host_data, 16'h0F1E);
        stub_word = 16'hE1F0;
        pulse_start();
        chk(host_busy, "R10 accepted at strobe", host_busy, 1);
        wait_valid(seen);
        chk(seen && host_data == 16'hE1F0, "R10 second word", host_data, 16'hE1F0);
    endtask

    initial begin
        t_reset_cal();
        t_convert(16'hA5C3, 1'b0, 6, "R6 slow");
        t_convert(16'h8001, 1'b0, 4, "R6 slow edges");
        t_convert(16'h3C96, 1'b1, 1, "R7 fast half1");
        t_convert(16'hFFFE, 1'b1, 0, "R7 fast half0");
        t_convert(16'h1234, 1'b1, 5, "R7 fast slowclk");
        t_busy_ignore();
        t_back_to_back();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(150000 * CLK_NS);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule